// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This unit holds a free-running 32-bit counter and a 32-bit compare value. The counter steps by one on every cycle where the tick enable is high. When a tick brings the counter up to the compare value, the unit raises hardware interrupt line 7 and holds it as a level. Software writes the counter and the compare value through a shared write port, and reads the counter on a dedicated output. A write to the compare value is the only way to acknowledge the interrupt.

A freeze input stops the counter. While it is high, the counter ignores both ticks and software writes. A 3-bit revision input controls a separate timer-status bit. Only when the revision is 1 is that bit set on a match and cleared on a compare write; at any other revision it keeps its value. The unit does not generate its clock and does not prioritise interrupts.

Top module: `cct_timer`

## Requirements
- R1: After reset, count_o is 0x00000001, irq_o is all zero, and status_o is 0. The compare value is 0.
- R2: While disable_count_i is 0 and no count write is present, each cycle with tick_i high raises count_o by one in the next cycle. The counter wraps from 0xFFFFFFFF to 0x00000000.
- R3: A write with wr_en_i=1 and wr_sel_i=0 (count select) loads wr_data_i into the counter, visible in the next cycle. The write wins over a tick in the same cycle.
- R4: While disable_count_i is 1, count_o does not change, whatever tick_i and count writes do.
- R5: A match occurs when a tick that takes effect increments the counter to equal the compare value. It sets irq_o[7] in the next cycle, and irq_o[7] stays high through further ticks until a compare write. irq_o bits 0 to 6 are always 0.
- R6: A write with wr_en_i=1 and wr_sel_i=1 (compare select) loads the compare value and drives irq_o[7] low in the next cycle. This also holds when a match would occur in the same cycle.
- R7: When arch_rev_i equals 3'd1, status_o is set by a match and cleared by a compare write, both in the next cycle. At any other arch_rev_i value, status_o keeps its value.
- R8: Only a tick can signal a match. Writing the counter equal to the compare value, or writing the compare value equal to the counter, leaves irq_o[7] low. In that case the next match needs a full wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| disable_count_i | input | 1 | Freezes the counter when high |
| arch_rev_i | input | 3 | Revision field; value 1 enables status-bit updates |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 count, 1 compare |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| irq_o | output | 8 | Hardware interrupt lines, only line 7 used |
| status_o | output | 1 | Timer-interrupt status bit |

## Verification
The assertions assume that each input stays stable for a whole clock cycle. They also assume that a same-cycle count write and tick resolve in favour of the write, and that arch_rev_i can change on any cycle. The bench changes inputs only at falling edges. The stimulus sets the compare value a few counts ahead of the counter so that matches happen often. It freezes the counter in short bursts and cycles arch_rev_i through 0, 1 and 2, so the status bit is seen both frozen and updating.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } wr_sel_e;

  localparam int unsigned CNT_W      = 32;
  localparam int unsigned REV_W      = 3;
  localparam int unsigned NUM_IRQ    = 8;
  localparam int unsigned TIMER_LINE = 7;
  localparam logic [REV_W-1:0] REV_STATUS = 3'd1;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned          W         = 32,
  parameter logic [W-1:0]         RESET_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         freeze_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] count_o,
  output logic         inc_o
);
  logic [W-1:0] cnt_q;

  // load beats tick; freeze beats both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= RESET_VAL;
    else if (!freeze_i) begin
      if (load_i)       cnt_q <= load_data_i;
      else if (tick_i)  cnt_q <= cnt_q + W'(1);
    end
  end

  assign inc_o   = tick_i && !freeze_i && !load_i;
  assign count_o = cnt_q;

  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !freeze_i && !load_i) |=> (count_o == $past(count_o) + W'(1)));

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !freeze_i) |=> (count_o == $past(load_data_i)));

  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(count_o));
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int unsigned      W          = 32,
  parameter int unsigned      REV_W      = 3,
  parameter int unsigned      NUM_IRQ    = 8,
  parameter int unsigned      IRQ_LINE   = 7,
  parameter logic [REV_W-1:0] REV_STATUS = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic [W-1:0]       count_i,
  input  logic               cmp_we_i,
  input  logic [W-1:0]       cmp_data_i,
  input  logic [REV_W-1:0]   rev_i,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               status_o
);
  logic [W-1:0] cmp_q;
  logic         irq_q, status_q, hit, rev_ok;

  // a match is only produced by an increment landing on compare
  assign hit    = inc_i && ((count_i + W'(1)) == cmp_q);
  assign rev_ok = (rev_i == REV_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= cmp_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (cmp_we_i) irq_q <= 1'b0;
    else if (hit)      irq_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 status_q <= 1'b0;
    else if (rev_ok) begin
      if (cmp_we_i)              status_q <= 1'b0;
      else if (hit)              status_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    if (g == IRQ_LINE) begin : g_timer
      assign irq_o[g] = irq_q;
    end else begin : g_idle
      assign irq_o[g] = 1'b0;
    end
  end

  assign status_o = status_q;

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> !irq_o[IRQ_LINE]);

  a_r5_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[IRQ_LINE] && !cmp_we_i) |=> irq_o[IRQ_LINE]);

  a_r7_status_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rev_ok |=> $stable(status_o));

  a_r7_status_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_ok && cmp_we_i) |=> !status_o);
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                disable_count_i,
  input  logic [REV_W-1:0]    arch_rev_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  output logic [CNT_W-1:0]    count_o,
  output logic [NUM_IRQ-1:0]  irq_o,
  output logic                status_o
);
  wr_sel_e    sel;
  logic       cnt_we, cmp_we, inc;

  assign sel    = wr_sel_e'(wr_sel_i);
  assign cnt_we = wr_en_i && (sel == SEL_COUNT);
  assign cmp_we = wr_en_i && (sel == SEL_COMPARE);

  cct_counter #(
    .W         (CNT_W),
    .RESET_VAL (CNT_W'(1))
  ) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .freeze_i    (disable_count_i),
    .load_i      (cnt_we),
    .load_data_i (wr_data_i),
    .count_o     (count_o),
    .inc_o       (inc)
  );

  cct_compare #(
    .W          (CNT_W),
    .REV_W      (REV_W),
    .NUM_IRQ    (NUM_IRQ),
    .IRQ_LINE   (TIMER_LINE),
    .REV_STATUS (REV_STATUS)
  ) i_compare (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .count_i    (count_o),
    .cmp_we_i   (cmp_we),
    .cmp_data_i (wr_data_i),
    .rev_i      (arch_rev_i),
    .irq_o      (irq_o),
    .status_o   (status_o)
  );

  a_r8_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && !disable_count_i) |=> !$rose(irq_o[TIMER_LINE]));
endmodule

// File: tb/test_cct_timer.sv
`timescale 1ns/1ps
module test_cct_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, dis = 1'b0, we = 1'b0, sel = 1'b0;
  logic [2:0]  rev = 3'd0;
  logic [31:0] data = '0;
  logic [31:0] count;
  logic [7:0]  irq;
  logic        status;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cnt, m_cmp;
  logic        m_irq, m_st;

  always #2.5 clk = ~clk;

  cct_timer i_cct_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .disable_count_i(dis),
    .arch_rev_i(rev), .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(data),
    .count_o(count), .irq_o(irq), .status_o(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    check({req, " count"}, count, m_cnt);
    check({req, " irq"}, {24'd0, irq}, {24'd0, m_irq, 7'd0});
    check({req, " status"}, {31'd0, status}, {31'd0, m_st});
  endtask

  // drive one cycle at a falling edge, advance model, check at the next falling edge
  task automatic cyc(string req, logic t, logic w, logic s, logic [31:0] d,
                     logic f, logic [2:0] r);
    logic wc, wp, hit;
    tick = t; we = w; sel = s; data = d; dis = f; rev = r;
    wc  = w && !s;
    wp  = w && s;
    hit = t && !f && !wc && (m_cnt + 32'd1 == m_cmp);
    if (!f) begin
      if (wc)     m_cnt = d;
      else if (t) m_cnt = m_cnt + 32'd1;
    end
    if (wp) m_cmp = d;
    if (wp) m_irq = 1'b0; else if (hit) m_irq = 1'b1;
    if (r == 3'd1) begin
      if (wp) m_st = 1'b0; else if (hit) m_st = 1'b1;
    end
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic ticks(string req, int n, logic [2:0] r);
    for (int i = 0; i < n; i++) cyc(req, 1, 0, 0, 0, 0, r);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cnt = 32'd1; m_cmp = 32'd0; m_irq = 1'b0; m_st = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    ticks("R2", 5, 3'd1);
    cyc("R3", 1, 1, 0, 32'd100, 0, 3'd1);           // count write beats tick
    check("R3 load", count, 32'd100);
    cyc("R6", 0, 1, 1, 32'd104, 0, 3'd1);           // compare 4 ahead
    ticks("R5", 3, 3'd1);
    check("R5 pre", {31'd0, irq[7]}, 32'd0);
    ticks("R5", 1, 3'd1);
    check("R5 set", {31'd0, irq[7]}, 32'd1);
    check("R7 set", {31'd0, status}, 32'd1);
    ticks("R5", 6, 3'd1);
    check("R5 hold", {31'd0, irq[7]}, 32'd1);
    cyc("R6", 1, 1, 1, 32'd200, 0, 3'd1);
    check("R6 ack", {31'd0, irq[7]}, 32'd0);
    check("R7 clr", {31'd0, status}, 32'd0);

    // revision 0: status untouched on match
    cyc("R7", 0, 1, 1, count + 32'd2, 0, 3'd0);
    ticks("R7", 3, 3'd0);
    check("R7 rev0 irq", {31'd0, irq[7]}, 32'd1);
    check("R7 rev0 st", {31'd0, status}, 32'd0);
    cyc("R7", 0, 1, 1, count + 32'd2, 0, 3'd1);
    ticks("R7", 2, 3'd1);
    check("R7 rev1 st", {31'd0, status}, 32'd1);
    cyc("R7", 0, 1, 1, 32'd5, 0, 3'd2);             // rev 2 ack keeps status
    check("R7 rev2 st", {31'd0, status}, 32'd1);
    check("R6 rev2 irq", {31'd0, irq[7]}, 32'd0);

    // freeze
    cyc("R4", 1, 0, 0, 0, 1, 3'd1);
    cyc("R4", 1, 1, 0, 32'h1234, 1, 3'd1);
    cyc("R4", 0, 1, 0, 32'h5678, 1, 3'd1);
    check("R4 frozen", count, m_cnt);

    // wrap
    cyc("R2", 0, 1, 0, 32'hFFFF_FFFE, 0, 3'd1);
    ticks("R2", 2, 3'd1);
    check("R2 wrap", count, 32'h0);

    // count written equal to compare: no match
    cyc("R8", 0, 1, 1, 32'd50, 0, 3'd1);
    cyc("R8", 0, 1, 0, 32'd50, 0, 3'd1);
    ticks("R8", 4, 3'd1);
    check("R8 cnt eq", {31'd0, irq[7]}, 32'd0);
    // compare written equal to count: no match
    cyc("R8", 0, 1, 1, count, 0, 3'd1);
    ticks("R8", 2, 3'd1);
    check("R8 cmp eq", {31'd0, irq[7]}, 32'd0);

    // compare write in the cycle a tick would match
    cyc("R6", 0, 1, 1, count + 32'd1, 0, 3'd1);
    cyc("R6", 1, 1, 1, 32'd9, 0, 3'd1);
    check("R6 same", {31'd0, irq[7]}, 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic w, s;
      logic [31:0] d;
      r = $urandom % 100;
      w = (r >= 88);
      s = $urandom % 2;
      if (s) d = m_cnt + ($urandom % 8);
      else   d = ($urandom % 4 == 0) ? m_cmp - ($urandom % 4) : $urandom;
      cyc("R5", r < 70, w, s, d, ($urandom % 16) == 0, 3'($urandom % 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule